// File: doc/BRIEF.md
# DDR2 On-Die Termination Timing Controller

This block decides, on the memory device side, when the on-die termination of the data lines is switched on and off in response to the termination request pin. It works in one of two ways. The first is a clocked path: the request is captured on rising clock edges, and the enable follows it with a fixed latency. The second is a direct path: the enable simply tracks the pin. Which path is in force depends on the clock-enable level, the kind of power-down the device is in and the fast/slow-exit setting of the mode register.

In the clocked path the request is registered on every rising edge. Termination comes on two full cycles after a high sample. It goes off two and a half cycles after a low sample, and that release is timed by a falling clock edge. In the direct path, which covers the power-down states where the delay-locked loop is stopped, there is no clock latency. When the device moves into the direct path, every request still in flight in the clocked pipeline is discarded. A second output reports which path is in force.

Top module: `odt_term_ctrl`

## Requirements
- R1: With `cke` high, the clocked path is used and `async_mode` is 0, whatever `pd_precharge` and `slow_exit` are.
- R2: With `cke` low, `pd_precharge` 0 (active power-down) and `slow_exit` 0 (fast exit), the clocked path is used and `async_mode` is 0.
- R3: With `cke` low and `pd_precharge` 1 (precharge power-down), the direct path is used and `async_mode` is 1, for either value of `slow_exit`.
- R4: With `cke` low, `pd_precharge` 0 and `slow_exit` 1 (slow exit), the direct path is used and `async_mode` is 1.
- R5: In the clocked path, a high `odt` sampled at rising edge N drives `term_en` high right after rising edge N+2.
- R6: In the clocked path, a low `odt` sampled at rising edge N, following a high one, drives `term_en` low right after the falling edge between rising edges N+2 and N+3. So `term_en` stays high during the high clock phase after edge N+2.
- R7: In the direct path, `term_en` equals `odt` at all times, with no clock edge in between.
- R8: At every rising edge where the direct path is selected, all pending clocked requests are discarded. After a return to the clocked path, `term_en` stays low until a new high sample has crossed the full turn-on latency.
- R9: While `rst` is high, `term_en` is 0 in either path. At the first rising edge after `rst` falls, the pipeline holds no requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock; rising edges sample, one falling-edge stage adds the half cycle |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low means a power-down state |
| odt | input | 1 | Termination request pin |
| pd_precharge | input | 1 | 1: precharge power-down, 0: active power-down (used only when `cke` is low) |
| slow_exit | input | 1 | Mode-register exit setting; 1: slow exit with the loop stopped, 0: fast exit |
| term_en | output | 1 | Termination enable |
| async_mode | output | 1 | 1: direct path in force, 0: clocked path in force |

## Verification
A wrong bit in the clocked pipeline shows at `term_en` within at most two and a half cycles. It appears as an enable that rises one cycle early or late, or as a release on a rising edge instead of a falling one. The bench therefore compares the output in both clock phases of every cycle. A stale request that survived a flush shows up the first time the clocked path is chosen again, because the output goes high before any fresh high sample could have got there. A mode-decode fault shows up in the same cycle, either on `async_mode` or on `term_en` failing to follow the pin.

// File: rtl/odt_term_pkg.sv
package odt_term_pkg;

    typedef enum logic {
        TM_CLOCKED = 1'b0,
        TM_DIRECT  = 1'b1
    } timing_mode_e;

    typedef struct packed {
        logic on_path;
        logic off_path;
    } sync_term_t;

    function automatic timing_mode_e pick_mode(
        input logic cke,
        input logic pd_precharge,
        input logic slow_exit
    );
        timing_mode_e m;
        if (cke) begin
            m = TM_CLOCKED;
        end else if (pd_precharge) begin
            m = TM_DIRECT;
        end else if (slow_exit) begin
            m = TM_DIRECT;
        end else begin
            m = TM_CLOCKED;
        end
        return m;
    endfunction

endpackage

// File: rtl/odt_mode_sel.sv
module odt_mode_sel
    import odt_term_pkg::*;
(
    input  logic         cke,
    input  logic         pd_precharge,
    input  logic         slow_exit,
    output timing_mode_e mode,
    output logic         flush
);
    always_comb begin
        mode  = pick_mode(cke, pd_precharge, slow_exit);
        flush = (mode == TM_DIRECT);
    end
endmodule

// File: rtl/odt_sync_pipe.sv
module odt_sync_pipe
    import odt_term_pkg::*;
#(
    parameter int ON_LAT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       odt,
    output sync_term_t term
);
    localparam int STAGES = ON_LAT + 1;

    logic [STAGES-1:0] stage_q;
    logic              half_q;

    generate
        if (STAGES > 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= {stage_q[STAGES-2:0], odt};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst || flush) begin
                    stage_q <= '0;
                end else begin
                    stage_q <= odt;
                end
            end
        end
    endgenerate

    always_ff @(negedge clk) begin
        if (rst || flush) begin
            half_q <= 1'b0;
        end else begin
            half_q <= stage_q[STAGES-1];
        end
    end

    always_comb begin
        term.on_path  = stage_q[STAGES-1];
        term.off_path = half_q;
    end
endmodule

// File: rtl/odt_out_sel.sv
module odt_out_sel
    import odt_term_pkg::*;
(
    input  logic         rst,
    input  timing_mode_e mode,
    input  logic         odt,
    input  sync_term_t   term,
    output logic         term_en
);
    always_comb begin
        if (rst) begin
            term_en = 1'b0;
        end else if (mode == TM_DIRECT) begin
            term_en = odt;
        end else begin
            term_en = term.on_path | term.off_path;
        end
    end
endmodule

// File: rtl/odt_term_ctrl.sv
module odt_term_ctrl
    import odt_term_pkg::*;
#(
    parameter int ON_LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    input  logic odt,
    input  logic pd_precharge,
    input  logic slow_exit,
    output logic term_en,
    output logic async_mode
);
    timing_mode_e mode;
    logic         flush;
    sync_term_t   sterm;

    odt_mode_sel u_mode (
        .cke          (cke),
        .pd_precharge (pd_precharge),
        .slow_exit    (slow_exit),
        .mode         (mode),
        .flush        (flush)
    );

    odt_sync_pipe #(.ON_LAT(ON_LAT)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .odt   (odt),
        .term  (sterm)
    );

    odt_out_sel u_out (
        .rst     (rst),
        .mode    (mode),
        .odt     (odt),
        .term    (sterm),
        .term_en (term_en)
    );

    assign async_mode = (mode == TM_DIRECT);
endmodule

// File: rtl/odt_term_ctrl_chk.sv
module odt_term_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic cke,
    input logic odt,
    input logic pd_precharge,
    input logic slow_exit,
    input logic term_en,
    input logic async_mode
);
    assert_cke_high_clocked_R1: assert property (@(posedge clk) disable iff (rst)
        cke |-> !async_mode);

    assert_fast_exit_clocked_R2: assert property (@(posedge clk) disable iff (rst)
        (!cke && !pd_precharge && !slow_exit) |-> !async_mode);

    assert_precharge_direct_R3: assert property (@(posedge clk) disable iff (rst)
        (!cke && pd_precharge) |-> async_mode);

    assert_slow_exit_direct_R4: assert property (@(posedge clk) disable iff (rst)
        (!cke && !pd_precharge && slow_exit) |-> async_mode);

    assert_direct_follows_pin_R7: assert property (@(posedge clk) disable iff (rst)
        async_mode |-> (term_en == odt));

    assert_no_stale_after_flush_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(async_mode) && !async_mode && !$past(rst)) |-> !term_en);

    always_comb begin
        if (rst) begin
            assert_reset_off_R9: assert (!term_en);
        end
    end
endmodule

bind odt_term_ctrl odt_term_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cke          (cke),
    .odt          (odt),
    .pd_precharge (pd_precharge),
    .slow_exit    (slow_exit),
    .term_en      (term_en),
    .async_mode   (async_mode)
);

// File: tb/odt_term_ctrl_tb.sv
`timescale 1ns/1ps
module odt_term_ctrl_tb_top;
    localparam int LAT = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cke = 1'b1;
    logic odt = 1'b0;
    logic pd_precharge = 1'b0;
    logic slow_exit = 1'b0;
    logic term_en;
    logic async_mode;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // behavioural reference state
    bit hist[$];
    bit m_half = 1'b0;

    odt_term_ctrl #(.ON_LAT(LAT)) dut_i (
        .clk(clk), .rst(rst), .cke(cke), .odt(odt),
        .pd_precharge(pd_precharge), .slow_exit(slow_exit),
        .term_en(term_en), .async_mode(async_mode)
    );

    always #2.5 clk = ~clk;

    function automatic bit want_direct();
        if (cke) return 1'b0;
        if (pd_precharge) return 1'b1;
        return slow_exit;
    endfunction

    function automatic bit want_term();
        if (rst) return 1'b0;
        if (want_direct()) return odt;
        return hist[LAT] | m_half;
    endfunction

    initial begin
        for (int i = 0; i <= LAT; i++) hist.push_back(1'b0);
    end

    always @(posedge clk) begin
        cycles++;
        if (rst || want_direct()) begin
            foreach (hist[i]) hist[i] = 1'b0;
        end else begin
            hist.push_front(odt);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (rst || want_direct()) m_half = 1'b0;
        else m_half = hist[LAT];
    end

    task automatic check(input string tag);
        bit et, em;
        et = want_term();
        em = want_direct();
        checks++;
        if (term_en !== et) begin
            failures++;
            $display("FAIL %s term_en actual=%b expected=%b t=%0t", tag, term_en, et, $time);
        end
        checks++;
        if (async_mode !== em) begin
            failures++;
            $display("FAIL %s async_mode actual=%b expected=%b t=%0t", tag, async_mode, em, $time);
        end
    endtask

    // one cycle: drive after rising edge, check both phases
    task automatic step(input bit o, input string tag);
        @(posedge clk);
        #1 odt = o;
        #0.5 check(tag);
        #2.5 check(tag);
    endtask

    task automatic set_mode(input bit c, input bit p, input bit s);
        cke = c; pd_precharge = p; slow_exit = s;
    endtask

    initial begin
        // R9 reset state
        repeat (3) begin
            @(posedge clk);
            #1 odt = 1'b1;
            #0.5 check("R9");
        end
        @(posedge clk); #1 rst = 1'b0; odt = 1'b0;
        #0.5 check("R9");

        // R5 / R6 clocked pulses with cke high (R1)
        set_mode(1, 0, 0);
        step(1, "R5"); step(1, "R5"); step(1, "R5");
        step(0, "R6"); step(0, "R6"); step(0, "R6"); step(0, "R6");
        step(1, "R5"); step(0, "R6"); step(0, "R6"); step(0, "R6"); step(0, "R6");
        step(1, "R5"); step(0, "R6"); step(1, "R5"); step(0, "R6");
        repeat (4) step(0, "R6");

        // R2 fast-exit power-down keeps clocked latency
        set_mode(0, 0, 0);
        step(1, "R2"); step(1, "R2"); step(0, "R2"); repeat (4) step(0, "R2");

        // all mode combinations
        for (int k = 0; k < 8; k++) begin
            string tag;
            set_mode(k[2], k[1], k[0]);
            if (k[2]) tag = "R1";
            else if (k[1]) tag = "R3";
            else if (k[0]) tag = "R4";
            else tag = "R2";
            step(k[0] ^ k[1], tag);
            step(1, tag);
        end

        // R7 direct path: pin changes mid-phase are followed at once
        set_mode(0, 1, 0);
        step(0, "R7");
        for (int i = 0; i < 6; i++) begin
            #0.7 odt = ~odt;
            #0.3 check("R7");
        end
        set_mode(0, 0, 1);
        #0.2 odt = 1'b1; #0.3 check("R7");
        #0.2 odt = 1'b0; #0.3 check("R7");

        // R8 flush: high in flight, go direct with pin low, return
        set_mode(1, 0, 0);
        step(1, "R8"); step(1, "R8");
        set_mode(0, 1, 1);
        step(0, "R8");
        set_mode(1, 0, 0);
        step(0, "R8"); step(1, "R8"); step(1, "R8"); step(1, "R8"); step(0, "R8");
        set_mode(0, 1, 0);
        step(1, "R8");
        set_mode(0, 0, 0);
        step(1, "R8"); step(1, "R8"); step(1, "R8"); step(0, "R8"); step(0, "R8");

        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            bit [3:0] r;
            r = 4'($urandom);
            if (r[3:2] == 2'b00) set_mode(r[1], r[0], r[2]);
            else set_mode(1, 0, 0);
            step(($urandom % 3) != 0, "R5");
        end

        // R9 reset mid-run clears pipeline
        set_mode(1, 0, 0);
        step(1, "R9"); step(1, "R9"); step(1, "R9");
        @(posedge clk); #1 rst = 1'b1; #0.5 check("R9");
        @(posedge clk); #1 rst = 1'b0; #0.5 check("R9");
        step(0, "R9"); step(0, "R9"); step(0, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        failures++;
        $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule